// File: doc/BRIEF.md
# Key-Protected Flash Sequencer Reset Register

This block is a 16-bit control register on the peripheral bus. It holds one bit that puts a flash programming sequencer into reset. When that bit is set, the sequencer's reset output is asserted. This forcibly ends any program or erase operation in progress and clears the sequencer's mode-entry register, so no sequencer command can be issued. While the reset is held, the block refuses flash read requests: each refused read completes with zero data and a one-cycle error strobe.

The bit can be changed only by a word-sized write whose upper byte carries a fixed key (8'hCC by default). The key is never stored. When the on-chip memory is disabled, the register reads as zero and ignores every write.

Software must keep the bit set for a minimum number of clock cycles (`MIN_HOLD`) so that the programming voltage can discharge. A three-state machine tracks the hold time:

- **RUN**: the bit is 0.
- **HOLD_WAIT**: the bit is 1 and the minimum time has not yet passed.
- **HOLD_MET**: the bit is 1 and the minimum time has passed.

The transitions are:

- **RUN→HOLD_WAIT** on an accepted write of 1.
- **HOLD_WAIT→HOLD_MET** when the count completes.
- **HOLD_WAIT→RUN** on an accepted write of 0. This is an early release, and it flags a violation.
- **HOLD_MET→RUN** on an accepted write of 0.

Top module: `flash_seq_reset_ctl`

## Requirements
- R1: Register bit 0 is the sequencer reset control. Bits 15 to 1 always read as 0, including the key byte after it was written.
- R2: A register write is accepted when all of the following hold: `reg_wr`, `reg_sel` and `mem_en` are high, `reg_size` is 2'b01 (word), and `reg_wdata[15:8]` equals 8'hCC. Bit 0 then takes `reg_wdata[0]`, visible on `seq_rst` after the write edge.
- R3: A write with `reg_size` other than 2'b01 (2'b00 means byte), or with any other key byte, leaves bit 0 unchanged.
- R4: While `mem_en` is low, register reads return 16'h0000 and all writes are ignored.
- R5: After system reset, `seq_rst`, `hold_done`, `hold_viol`, `reg_rdata`, `fl_rd_valid` and `fl_rd_err` are all 0.
- R6: `seq_rst` equals register bit 0 at all times.
- R7: A flash read request made while `seq_rst` is 1 gives, on the next cycle, `fl_rd_valid`=1, `fl_rdata`=0 and `fl_rd_err`=1 for that one cycle only. Otherwise the request returns `fl_rdata_in` with `fl_rd_err`=0.
- R8: `hold_done` rises exactly `MIN_HOLD` cycles after `seq_rst` rises, and falls when `seq_rst` falls.
- R9: `hold_viol` sets when bit 0 is cleared after fewer than `MIN_HOLD` held cycles. It stays set until the next rise of bit 0 or a system reset.
- R10: Register read data is registered. It appears the cycle after `reg_rd`, and `reg_rdata` is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| mem_en | input | 1 | On-chip memory enabled |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 1 | Address matches this register |
| reg_size | input | 2 | Access size, 2'b00 byte, 2'b01 word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| fl_rd_req | input | 1 | Flash read request |
| fl_rdata_in | input | 16 | Data from flash array |
| fl_rd_valid | output | 1 | Flash read completes |
| fl_rdata | output | 16 | Flash read data, zero when refused |
| fl_rd_err | output | 1 | Refused flash read strobe |
| seq_rst | output | 1 | Reset to the sequencer |
| hold_done | output | 1 | Minimum hold time reached |
| hold_viol | output | 1 | Reset released too early |

## Verification
The hardest situation to reach from the ports is a release at the exact boundary cycle. This is the edge at which the hold counter would move the machine to HOLD_MET, and a clearing write lands on that same edge; it must count as a legal release. The bench reaches it by counting clock edges from the setting write and issuing the clearing write at every offset from 1 to `MIN_HOLD`+2. At each offset it predicts `hold_done` and `hold_viol` from the offset alone. A full sweep of all four size codes against all 256 key bytes, for both set and clear data, covers write acceptance.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_HOLD_WAIT = 2'd1,
        ST_HOLD_MET  = 2'd2
    } hold_st_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_WORD = 2'b01;
endpackage

// File: rtl/fsr_wr_decode.sv
module fsr_wr_decode
    import fsr_pkg::*;
#(
    parameter logic [7:0] KEY = 8'hCC
) (
    input  logic       wr,
    input  logic       sel,
    input  logic       mem_en,
    input  logic [1:0] size,
    input  logic [7:0] key_byte,
    input  logic       data_bit,
    output logic       set_req,
    output logic       clr_req
);
    logic accept;

    always_comb begin
        accept  = wr && sel && mem_en && (size == SZ_WORD) && (key_byte == KEY);
        set_req = accept && data_bit;
        clr_req = accept && !data_bit;
    end
endmodule

// File: rtl/fsr_hold_fsm.sv
module fsr_hold_fsm
    import fsr_pkg::*;
#(
    parameter int MIN_HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic rst_bit,
    output logic hold_done,
    output logic hold_viol
);
    localparam int CW = (MIN_HOLD > 1) ? $clog2(MIN_HOLD) : 1;
    localparam logic [CW-1:0] LAST = CW'(MIN_HOLD - 1);

    hold_st_e      state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          viol_q, viol_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            viol_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            viol_q  <= viol_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        viol_d  = viol_q;
        unique case (state_q)
            ST_RUN: begin
                if (set_req) begin
                    state_d = ST_HOLD_WAIT;
                    cnt_d   = '0;
                    viol_d  = 1'b0;
                end
            end
            ST_HOLD_WAIT: begin
                if (clr_req) begin
                    state_d = ST_RUN;
                    viol_d  = (cnt_q != LAST);
                end else if (cnt_q == LAST) begin
                    state_d = ST_HOLD_MET;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_HOLD_MET: begin
                if (clr_req) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        rst_bit   = (state_q != ST_RUN);
        hold_done = (state_q == ST_HOLD_MET);
        hold_viol = viol_q;
    end

    AST_DONE_NEEDS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        hold_done |-> rst_bit); // R8
    AST_LATE_RELEASE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rst_bit) && $past(hold_done)) |-> !hold_viol); // R9
endmodule

// File: rtl/fsr_rd_path.sv
module fsr_rd_path #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_rd,
    input  logic          mem_en,
    input  logic          rst_bit,
    input  logic          fl_rd_req,
    input  logic [DW-1:0] fl_rdata_in,
    output logic [DW-1:0] reg_rdata,
    output logic          fl_rd_valid,
    output logic [DW-1:0] fl_rdata,
    output logic          fl_rd_err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata   <= '0;
            fl_rd_valid <= 1'b0;
            fl_rdata    <= '0;
            fl_rd_err   <= 1'b0;
        end else begin
            reg_rdata   <= (reg_rd && mem_en) ? {{(DW-1){1'b0}}, rst_bit} : '0;
            fl_rd_valid <= fl_rd_req;
            fl_rdata    <= (fl_rd_req && !rst_bit) ? fl_rdata_in : '0;
            fl_rd_err   <= fl_rd_req && rst_bit;
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DW-1:1] == '0); // R1
    AST_BLOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_rd_req && rst_bit) |=> (fl_rd_err && fl_rdata == '0)); // R7
endmodule

// File: rtl/flash_seq_reset_ctl.sv
module flash_seq_reset_ctl
    import fsr_pkg::*;
#(
    parameter logic [7:0] KEY      = 8'hCC,
    parameter int         MIN_HOLD = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mem_en,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic        reg_sel,
    input  logic [1:0]  reg_size,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        fl_rd_req,
    input  logic [15:0] fl_rdata_in,
    output logic        fl_rd_valid,
    output logic [15:0] fl_rdata,
    output logic        fl_rd_err,
    output logic        seq_rst,
    output logic        hold_done,
    output logic        hold_viol
);
    logic set_req, clr_req, rst_bit;
    logic unused_rsvd;

    assign unused_rsvd = ^reg_wdata[7:1];

    fsr_wr_decode #(.KEY(KEY)) u_dec (
        .wr      (reg_wr),
        .sel     (reg_sel),
        .mem_en  (mem_en),
        .size    (reg_size),
        .key_byte(reg_wdata[15:8]),
        .data_bit(reg_wdata[0]),
        .set_req (set_req),
        .clr_req (clr_req)
    );

    fsr_hold_fsm #(.MIN_HOLD(MIN_HOLD)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (set_req),
        .clr_req  (clr_req),
        .rst_bit  (rst_bit),
        .hold_done(hold_done),
        .hold_viol(hold_viol)
    );

    fsr_rd_path #(.DW(16)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_rd     (reg_rd && reg_sel),
        .mem_en     (mem_en),
        .rst_bit    (rst_bit),
        .fl_rd_req  (fl_rd_req),
        .fl_rdata_in(fl_rdata_in),
        .reg_rdata  (reg_rdata),
        .fl_rd_valid(fl_rd_valid),
        .fl_rdata   (fl_rdata),
        .fl_rd_err  (fl_rd_err)
    );

    assign seq_rst = rst_bit;

    AST_BADKEY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && (reg_size != SZ_WORD || reg_wdata[15:8] != KEY))
        |=> $stable(seq_rst)); // R3
    AST_MEMOFF_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_en |=> $stable(seq_rst)); // R4
    AST_MEMOFF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel && !mem_en) |=> (reg_rdata == 16'h0000)); // R4
endmodule

// File: tb/flash_seq_reset_ctl_bench.sv
`timescale 1ns/1ps
module flash_seq_reset_ctl_bench;
    localparam int MH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_en = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
    logic [1:0]  reg_size = 2'b00;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        fl_rd_req = 1'b0;
    logic [15:0] fl_rdata_in = '0;
    logic        fl_rd_valid, fl_rd_err, seq_rst, hold_done, hold_viol;
    logic [15:0] fl_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    flash_seq_reset_ctl #(.KEY(8'hCC), .MIN_HOLD(MH)) u_flash_seq_reset_ctl (
        .clk(clk), .rst_n(rst_n), .mem_en(mem_en),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fl_rd_req(fl_rd_req), .fl_rdata_in(fl_rdata_in),
        .fl_rd_valid(fl_rd_valid), .fl_rdata(fl_rdata), .fl_rd_err(fl_rd_err),
        .seq_rst(seq_rst), .hold_done(hold_done), .hold_viol(hold_viol)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sz, input logic [15:0] d);
        reg_wr = 1'b1; reg_sel = 1'b1; reg_size = sz; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic rd(output logic [15:0] d);
        reg_rd = 1'b1; reg_sel = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; reg_sel = 1'b0;
        d = reg_rdata;
    endtask

    task automatic flrd(input logic [15:0] d, input logic held);
        fl_rd_req = 1'b1; fl_rdata_in = d;
        @(negedge clk);
        fl_rd_req = 1'b0;
        chk("R7 valid", fl_rd_valid, 1);
        chk("R7 data", fl_rdata, held ? 16'h0 : d);
        chk("R7 err", fl_rd_err, held);
        @(negedge clk);
        chk("R7 err one cycle", fl_rd_err, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] rdv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 reset state
        chk("R5 seq_rst", seq_rst, 0);
        chk("R5 hold_done", hold_done, 0);
        chk("R5 hold_viol", hold_viol, 0);
        chk("R5 rdata", reg_rdata, 0);
        chk("R5 fl_rd_valid", fl_rd_valid, 0);
        chk("R5 fl_rd_err", fl_rd_err, 0);

        // R2 R3: every size code against every key byte, set and clear
        for (int sz = 0; sz < 4; sz++) begin
            for (int k = 0; k < 256; k++) begin
                logic acc;
                acc = (sz == 1) && (k == 8'hCC);
                wr(sz[1:0], {k[7:0], 8'h01});
                chk(acc ? "R2 set accepted" : "R3 set ignored", seq_rst, acc);
                if (!acc) wr(2'b01, 16'hCC01);
                wr(sz[1:0], {k[7:0], 8'h00});
                chk(acc ? "R2 clear accepted" : "R3 clear ignored", seq_rst, !acc);
                if (!acc) wr(2'b01, 16'hCC00);
            end
        end

        // R1 R6 R10: readback shows only bit 0
        wr(2'b01, 16'hCCFF);
        chk("R6 seq_rst follows bit", seq_rst, 1);
        rd(rdv);
        chk("R1 readback set", rdv, 16'h0001);
        @(negedge clk);
        chk("R10 rdata zero without read", reg_rdata, 16'h0000);

        // R7 refused flash reads while held
        flrd(16'hA5A5, 1'b1);
        flrd(16'hFFFF, 1'b1);

        // R4 memory disabled
        mem_en = 1'b0;
        rd(rdv);
        chk("R4 read zero when disabled", rdv, 16'h0000);
        wr(2'b01, 16'hCC00);
        chk("R4 write ignored when disabled", seq_rst, 1);
        mem_en = 1'b1;
        rd(rdv);
        chk("R1 readback after re-enable", rdv, 16'h0001);
        wr(2'b01, 16'hCC00);
        rd(rdv);
        chk("R1 readback clear", rdv, 16'h0000);
        mem_en = 1'b0;
        wr(2'b01, 16'hCC01);
        chk("R4 set ignored when disabled", seq_rst, 0);
        mem_en = 1'b1;

        // R7 flash reads pass when not held
        flrd(16'h1234, 1'b0);
        flrd(16'hBEEF, 1'b0);

        // R8 R9: release after every hold length from 1 to MH+2
        for (int L = 1; L <= MH + 2; L++) begin
            wr(2'b01, 16'hCC01);
            chk("R9 viol cleared on rise", hold_viol, 0);
            for (int k = 0; k < L; k++) begin
                chk("R8 hold_done timing", hold_done, (k >= MH));
                if (k < L - 1) @(negedge clk);
            end
            wr(2'b01, 16'hCC00);
            chk("R8 hold_done falls", hold_done, 0);
            chk("R9 viol after release", hold_viol, (L < MH));
            repeat (3) @(negedge clk);
            chk("R9 viol persists", hold_viol, (L < MH));
        end

        // R9 violation cleared by system reset
        wr(2'b01, 16'hCC01);
        wr(2'b01, 16'hCC00);
        chk("R9 early release", hold_viol, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 viol cleared by reset", hold_viol, 0);
        chk("R5 seq_rst after reset", seq_rst, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule